// File: doc/BRIEF.md
# Fly-by Cycle-Stealing DMA Controller

This block moves a block of words between one I/O device and memory, and the processor does not handle the words. Software first loads the device address, the first memory address and the word count through a small register port. It then writes the control word, which holds the start bit and the direction. While the device holds its request line high, the controller asks the system arbiter for the bus. It uses each grant for exactly one bus cycle. In that cycle it drives the memory address, the device select and one complementary pair of read/write strobes, so the word passes directly from one side of the bus to the other. The controller has no data path and never holds a word.

Each stolen cycle advances the memory address and decrements the remaining count. When the count runs out, the controller leaves the busy state and raises an interrupt. The interrupt stays high until software clears it. The processor is only held off while the controller owns the bus, and its context is untouched. All pins are plain control and status signals. The block has no streaming data interface, so no valid/ready back-pressure applies. The device paces the transfer through its request line, and the arbiter paces it through the grant.

Top module: `flyby_dma`

## Requirements
- R1: After reset, bus_req, dack, every strobe and irq are low, and the status read (cfg_addr 0) returns 0.
- R2: The register port uses these addresses. Address 1 holds the device address, address 2 the memory address and address 3 the word count. Address 0 is control on write and status on read. The control bits are bit 0 = start, bit 1 = direction and bit 2 = clear interrupt. The status bits are bit 0 = busy and bit 1 = irq. Addresses 1 to 3 read back their current values.
- R3: bus_req rises only in the clock after one in which the block was busy and dreq was high. While dreq stays low, no request is made.
- R4: Each grant produces exactly one transfer cycle, with dack high for one clock. bus_req then stays low for at least one clock.
- R5: The direction bit selects the strobe pair. Direction 0 (device to memory) asserts io_rd with mem_wr. Direction 1 (memory to device) asserts mem_rd with io_wr. Two memory strobes or two I/O strobes are never high together. During the cycle, bus_addr carries the current memory address and bus_dev carries the device address.
- R6: After each transfer cycle, the memory address increments by one (modulo 2^AW) and the count decrements by one.
- R7: When the last word moves, busy clears and irq rises. irq then stays high until a control write with bit 2 set.
- R8: A start with a count of zero raises irq at once, does not set busy and causes no bus activity.
- R9: While busy, start and direction writes are ignored, and so are writes to addresses 1 to 3.
- R10: Strobes and dack are driven only in a cycle that follows a sampled grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Completion interrupt, held until cleared |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_addr | output | AW | Memory address during the stolen cycle, else 0 |
| bus_dev | output | DEVW | Device select during the stolen cycle, else 0 |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| dreq | input | 1 | Device ready for a word |
| dack | output | 1 | Device acknowledge, one clock per word |

## Verification
The assertions assume that the arbiter keeps bus_gnt high for as long as bus_req stays high once it has granted, and that it only grants after a request. The bench arbiter grants after a programmable delay and holds the grant until the request drops, so the stimulus stays within that assumption. The assertions also assume that software never writes a start while a transfer runs except to test R9. The bench issues those writes only in that directed case, and it holds dreq low there so that no stolen cycle coincides with them.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER, ST_GAP} seq_state_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DEV  = 2'd1;
  localparam logic [1:0] REG_MEM  = 2'd2;
  localparam logic [1:0] REG_CNT  = 2'd3;

  localparam int CTRL_START = 0;
  localparam int CTRL_DIR   = 1;
  localparam int CTRL_CLR   = 2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import flyby_dma_pkg::*;
#(
  parameter int AW   = 8,
  parameter int CW   = 8,
  parameter int DEVW = 4,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  input  logic            step,
  output logic            busy,
  output logic            irq,
  output logic            dir,
  output logic [DEVW-1:0] dev_addr,
  output logic [AW-1:0]   mem_addr
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] count;
  logic          wr_ctrl;
  logic          clr_hit;

  assign wr_ctrl = cfg_we && (cfg_addr == REG_CTRL);
  assign clr_hit = wr_ctrl && cfg_wdata[CTRL_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      irq      <= 1'b0;
      dir      <= 1'b0;
      dev_addr <= '0;
      mem_addr <= '0;
      count    <= '0;
    end else begin
      if (clr_hit) irq <= 1'b0;
      if (step) begin
        mem_addr <= mem_addr + 1'b1;
        count    <= count - 1'b1;
        if (count == CNT_ONE) begin
          busy <= 1'b0;
          irq  <= 1'b1;
        end
      end
      if (cfg_we && !busy) begin
        case (cfg_addr)
          REG_DEV: dev_addr <= cfg_wdata[DEVW-1:0];
          REG_MEM: mem_addr <= cfg_wdata[AW-1:0];
          REG_CNT: count    <= cfg_wdata[CW-1:0];
          default: begin
            if (cfg_wdata[CTRL_START]) begin
              dir <= cfg_wdata[CTRL_DIR];
              if (count == '0) irq  <= 1'b1;
              else             busy <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      REG_DEV: cfg_rdata = DW'(dev_addr);
      REG_MEM: cfg_rdata = DW'(mem_addr);
      REG_CNT: cfg_rdata = DW'(count);
      default: cfg_rdata = DW'({irq, busy});
    endcase
  end

  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (count == $past(count) - 1'b1) && (mem_addr == $past(mem_addr) + 1'b1)); // R6
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count == CNT_ONE) |=> (irq && !busy)); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_hit) |=> irq); // R7
  AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> (count == $past(count)) && (mem_addr == $past(mem_addr)) && (dir == $past(dir))); // R9
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import flyby_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic dir,
  input  logic dreq,
  input  logic bus_gnt,
  output logic bus_req,
  output logic xfer,
  output logic mem_rd,
  output logic mem_wr,
  output logic io_rd,
  output logic io_wr
);
  seq_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (busy && dreq) state_nx = ST_REQ;
      ST_REQ:  if (bus_gnt)      state_nx = ST_XFER;
      ST_XFER:                   state_nx = ST_GAP;
      default: state_nx = (busy && dreq) ? ST_REQ : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign xfer    = (state == ST_XFER);
  assign bus_req = (state == ST_REQ) || xfer;
  assign mem_rd  = xfer &&  dir;
  assign io_wr   = xfer &&  dir;
  assign mem_wr  = xfer && !dir;
  assign io_rd   = xfer && !dir;

  AST_REQ_NEEDS_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> ($past(dreq) && $past(busy))); // R3
  AST_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (!xfer && !bus_req)); // R4
  AST_PAIRED_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && !(io_rd && io_wr) && (mem_rd == io_wr) && (mem_wr == io_rd)); // R5
  AST_GRANTED_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer) |-> $past(bus_gnt)); // R10
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
  import flyby_dma_pkg::*;
#(
  parameter int AW   = 8,
  parameter int CW   = 8,
  parameter int DEVW = 4,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  output logic            irq,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic [AW-1:0]   bus_addr,
  output logic [DEVW-1:0] bus_dev,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            io_rd,
  output logic            io_wr,
  input  logic            dreq,
  output logic            dack
);
  logic            busy, dir, xfer;
  logic [DEVW-1:0] dev_addr;
  logic [AW-1:0]   mem_addr;

  dma_regs #(.AW(AW), .CW(CW), .DEVW(DEVW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .step(xfer),
    .busy(busy), .irq(irq), .dir(dir), .dev_addr(dev_addr), .mem_addr(mem_addr)
  );

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dir(dir), .dreq(dreq),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .xfer(xfer),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr)
  );

  assign dack     = xfer;
  assign bus_addr = xfer ? mem_addr : '0;
  assign bus_dev  = xfer ? dev_addr : '0;

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dack |-> (bus_addr == '0 && bus_dev == '0 && !mem_rd && !mem_wr && !io_rd && !io_wr)); // R5
  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !dack); // R8
endmodule

// File: tb/tb_flyby_dma.sv
module tb_flyby_dma;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, CW = 8, DEVW = 4, DW = 16;
  localparam int NV = 4;
  localparam int V_DIR [NV] = '{0, 1, 0, 1};
  localparam int V_DEV [NV] = '{3, 5, 9, 2};
  localparam int V_MEM [NV] = '{16, 64, 252, 128};
  localparam int V_CNT [NV] = '{5, 4, 6, 1};
  localparam int V_GDLY[NV] = '{0, 2, 1, 3};

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [DW-1:0] cfg_wdata = 0;
  logic [DW-1:0] cfg_rdata;
  logic irq, bus_req, mem_rd, mem_wr, io_rd, io_wr, dack;
  logic bus_gnt = 0;
  logic dreq = 0;
  logic [AW-1:0] bus_addr;
  logic [DEVW-1:0] bus_dev;

  int checks = 0, fails = 0;
  int gdly = 0, gcnt = 0;
  int dack_cnt = 0, gap_err = 0, own_err = 0;
  logic prev_dack = 0;
  logic dev_clr = 0;
  logic [7:0] dev_rptr = 0, dev_wptr = 0;
  logic [15:0] mem [256];
  logic [15:0] sink [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  flyby_dma #(.AW(AW), .CW(CW), .DEVW(DEVW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_dev(bus_dev),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .dreq(dreq), .dack(dack)
  );

  // arbiter, memory and device models
  always @(posedge clk) begin
    if (!bus_req) begin bus_gnt <= 0; gcnt <= 0; end
    else if (!bus_gnt) begin
      if (gcnt >= gdly) bus_gnt <= 1; else gcnt <= gcnt + 1;
    end
    if (dack) dack_cnt <= dack_cnt + 1;
    if (prev_dack && bus_req) gap_err <= gap_err + 1;
    if ((mem_rd || mem_wr || io_rd || io_wr || dack) && !bus_gnt) own_err <= own_err + 1;
    prev_dack <= dack;
    if (dev_clr) begin dev_rptr <= 0; dev_wptr <= 0; end
    else begin
      if (mem_wr && io_rd) begin
        mem[bus_addr] <= {4'hA, bus_dev, dev_rptr};
        dev_rptr <= dev_rptr + 1;
      end
      if (mem_rd && io_wr) begin
        sink[dev_wptr[3:0]] <= mem[bus_addr];
        dev_wptr <= dev_wptr + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); dev_clr = 1; @(negedge clk); dev_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int d0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, r);
    chk("R1 status", r, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 dack/strobes", {dack, mem_rd, mem_wr, io_rd, io_wr}, 0);
    chk("R1 irq", irq, 0);

    // vector table walk: R2 R4 R5 R6 R7
    dreq = 1;
    for (int v = 0; v < NV; v++) begin
      pulse_clr();
      gdly = V_GDLY[v];
      for (int i = 0; i < V_CNT[v]; i++)
        mem[(V_MEM[v] + i) % 256] = 16'h5000 + 16'(v * 16 + i);
      wr(2'd1, 16'(V_DEV[v]));
      wr(2'd2, 16'(V_MEM[v]));
      wr(2'd3, 16'(V_CNT[v]));
      rd(2'd1, r); chk("R2 dev readback", r, V_DEV[v]);
      rd(2'd3, r); chk("R2 count readback", r, V_CNT[v]);
      d0 = dack_cnt;
      wr(2'd0, 16'(V_DIR[v] * 2 + 1));
      wait_irq();
      @(negedge clk);
      chk("R4 one dack per word", dack_cnt - d0, V_CNT[v]);
      rd(2'd3, r); chk("R6 count exhausted", r, 0);
      rd(2'd2, r); chk("R6 address advanced", r, (V_MEM[v] + V_CNT[v]) % 256);
      rd(2'd0, r); chk("R7 busy low irq high", r, 2);
      for (int i = 0; i < V_CNT[v]; i++) begin
        if (V_DIR[v] == 0)
          chk("R5 dev->mem data", mem[(V_MEM[v] + i) % 256], {4'hA, 4'(V_DEV[v]), 8'(i)});
        else
          chk("R5 mem->dev data", sink[i], 16'h5000 + 16'(v * 16 + i));
      end
      wr(2'd0, 16'h4);
      rd(2'd0, r); chk("R7 irq cleared", r, 0);
    end
    chk("R4 request gap", gap_err, 0);

    // R3 no request without dreq, R9 writes ignored while busy
    dreq = 0; gdly = 0;
    pulse_clr();
    wr(2'd1, 16'd6);
    wr(2'd2, 16'h20);
    wr(2'd3, 16'd3);
    d0 = dack_cnt;
    wr(2'd0, 16'h1);
    wr(2'd3, 16'd9);
    wr(2'd2, 16'h99);
    wr(2'd0, 16'h3);
    repeat (8) @(negedge clk);
    chk("R3 no req while dreq low", bus_req, 0);
    chk("R3 no dack while dreq low", dack_cnt - d0, 0);
    rd(2'd0, r); chk("R9 still busy", r, 1);
    rd(2'd3, r); chk("R9 count kept", r, 3);
    rd(2'd2, r); chk("R9 address kept", r, 16'h20);
    dreq = 1;
    wait_irq();
    @(negedge clk);
    chk("R9 word count unchanged", dack_cnt - d0, 3);
    chk("R9 direction unchanged", mem[8'h22], {4'hA, 4'd6, 8'd2});
    // R7 sticky interrupt
    repeat (5) @(negedge clk);
    chk("R7 irq held", irq, 1);
    wr(2'd0, 16'h4);
    chk("R7 irq clear", irq, 0);

    // R8 zero count
    d0 = dack_cnt;
    wr(2'd3, 16'd0);
    wr(2'd0, 16'h1);
    rd(2'd0, r); chk("R8 irq without busy", r, 2);
    repeat (6) @(negedge clk);
    chk("R8 no bus activity", dack_cnt - d0, 0);
    chk("R8 no request", bus_req, 0);
    wr(2'd0, 16'h4);

    chk("R10 strobes only while granted", own_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule